// File: doc/BRIEF.md
# Fan Start-Up Power Sequencer

This block converts a small fan speed register into active-low speed-select lines and an active-low shutdown line for an external fan supply. Whenever the stored speed is zero and a nonzero value arrives, the fan first gets a full-speed kick for a fixed start interval. After the kick it settles to the requested speed. This makes slow speed settings start reliably.

The speed lines and the shutdown line are staggered by half the start interval. At turn-on the speed lines move first and shutdown is released half an interval later. At turn-off the order is reversed: shutdown is asserted first and the speed lines go back to their idle level half an interval later. The interval is measured in pulses of a prescaled tick input, not in clock cycles. An enable output for the timing oscillator is high only while a timed phase is running.

Top module: `fan_startup_seq`

## Requirements
- R1: After reset the speed lines `fs_no` are all 1, `shdn_no` is 0 and `osc_en_o` is 0.
- R2: A nonzero write while the fan is off (stored speed zero) drives `fs_no` to all 0 (full speed) on the next cycle. `shdn_no` stays 0 and `osc_en_o` goes to 1.
- R3: After HALF = START_TICKS/2 ticks of the kick, `shdn_no` goes to 1 while `fs_no` stays all 0.
- R4: After a further HALF ticks, `fs_no` equals the bitwise inverse of the stored speed, `shdn_no` is 1 and `osc_en_o` returns to 0.
- R5: A nonzero write while running changes `fs_no` to the inverse of the new value on the next cycle. There is no kick, and `osc_en_o` stays 0.
- R6: A nonzero write during the kick stores the new speed without disturbing the kick timing. The new speed appears when the kick ends.
- R7: A zero write while running sets `shdn_no` to 0 on the next cycle, with `fs_no` held and `osc_en_o` at 1. After HALF ticks, `fs_no` goes all 1 and `osc_en_o` goes to 0.
- R8: A zero write during either kick half aborts the kick and enters the shutdown sequence, with `fs_no` held at all 0 for HALF ticks.
- R9: A zero write while the fan is off has no effect on any output.
- R10: A nonzero write during the shutdown sequence restarts a full kick from its beginning: `fs_no` is all 0, `shdn_no` is 0, and the tick count restarts.
- R11: Timing advances only on cycles with `tick_i` high. Idle clock cycles and ticks outside a timed phase change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Speed register write strobe |
| wr_data_i | input | SPD_W | Speed value to write |
| tick_i | input | 1 | Prescaled timing tick, one cycle wide |
| fs_no | output | SPD_W | Speed-select lines, active low |
| shdn_no | output | 1 | Fan supply shutdown, active low |
| osc_en_o | output | 1 | Timing oscillator enable |

## Verification
The bench goes after the reversed staggering. A design that released shutdown together with the speed lines, or that dropped the speed lines before shutdown at turn-off, would show a wrong `shdn_no`/`fs_no` pair in the half-interval windows.

It also writes during the kick and during shutdown. A design that let a write cut the kick short would reach the set speed early. One that did not restart the count after a write during shutdown would release `shdn_no` after the leftover ticks instead of a full half interval.

Long idle gaps between ticks expose a timer that counts clocks, and zero writes while off expose a spurious oscillator enable.

// File: rtl/fan_seq_pkg.sv
package fan_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_KICK_LO = 3'd1,
    ST_KICK_HI = 3'd2,
    ST_RUN     = 3'd3,
    ST_STOP    = 3'd4
  } seq_state_e;
endpackage

// File: rtl/fan_seq_timer.sv
module fan_seq_timer #(
  parameter int unsigned HALF_TICKS = 4,
  localparam int unsigned CW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == CW'(HALF_TICKS - 1));
  assign done_o = run_i && tick_i && last && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  // R11: count only moves on a tick
  a_r11_count_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !clr_i |=> $stable(cnt_q));
endmodule

// File: rtl/fan_seq_ctrl.sv
module fan_seq_ctrl
  import fan_seq_pkg::*;
#(
  parameter int unsigned SPD_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SPD_W-1:0] wr_data_i,
  input  logic             half_done_i,
  output seq_state_e       state_o,
  output logic [SPD_W-1:0] speed_o,
  output logic             tmr_clr_o
);
  seq_state_e       state_q, state_d;
  logic [SPD_W-1:0] speed_q;
  logic             wr_zero, wr_nz;

  assign wr_zero = wr_en_i && (wr_data_i == '0);
  assign wr_nz   = wr_en_i && (wr_data_i != '0);

  always_comb begin
    state_d   = state_q;
    tmr_clr_o = 1'b0;
    unique case (state_q)
      ST_OFF: if (wr_nz) begin
        state_d = ST_KICK_LO; tmr_clr_o = 1'b1;
      end
      ST_KICK_LO: begin
        if (wr_zero) begin state_d = ST_STOP; tmr_clr_o = 1'b1; end
        else if (half_done_i) state_d = ST_KICK_HI;
      end
      ST_KICK_HI: begin
        if (wr_zero) begin state_d = ST_STOP; tmr_clr_o = 1'b1; end
        else if (half_done_i) state_d = ST_RUN;
      end
      ST_RUN: if (wr_zero) begin
        state_d = ST_STOP; tmr_clr_o = 1'b1;
      end
      ST_STOP: begin
        if (wr_nz) begin state_d = ST_KICK_LO; tmr_clr_o = 1'b1; end
        else if (half_done_i) state_d = ST_OFF;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      speed_q <= '0;
    end else begin
      state_q <= state_d;
      if (wr_en_i) speed_q <= wr_data_i;
    end
  end

  assign state_o = state_q;
  assign speed_o = speed_q;

  a_r2_kick_from_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_OFF && wr_nz |=> state_q == ST_KICK_LO);
  a_r8_abort_kick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_KICK_LO || state_q == ST_KICK_HI) && wr_zero |=> state_q == ST_STOP);
  a_r9_zero_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_OFF && wr_zero |=> state_q == ST_OFF);
  a_r5_no_rekick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RUN && wr_nz |=> state_q == ST_RUN && speed_q == $past(wr_data_i));
  a_r10_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_STOP && wr_nz |=> state_q == ST_KICK_LO);
endmodule

// File: rtl/fan_seq_drive.sv
module fan_seq_drive
  import fan_seq_pkg::*;
#(
  parameter int unsigned SPD_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  seq_state_e       state_i,
  input  logic [SPD_W-1:0] speed_i,
  output logic [SPD_W-1:0] fs_no,
  output logic             shdn_no,
  output logic             osc_en_o
);
  logic [SPD_W-1:0] hold_q;

  always_comb begin
    unique case (state_i)
      ST_KICK_LO: begin fs_no = '0;       shdn_no = 1'b0; osc_en_o = 1'b1; end
      ST_KICK_HI: begin fs_no = '0;       shdn_no = 1'b1; osc_en_o = 1'b1; end
      ST_RUN:     begin fs_no = ~speed_i; shdn_no = 1'b1; osc_en_o = 1'b0; end
      ST_STOP:    begin fs_no = hold_q;   shdn_no = 1'b0; osc_en_o = 1'b1; end
      default:    begin fs_no = '1;       shdn_no = 1'b0; osc_en_o = 1'b0; end
    endcase
  end

  // freeze speed lines at entry to shutdown
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hold_q <= '1;
    else if (state_i != ST_STOP) hold_q <= fs_no;
  end

  a_r3_shdn_after_fs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shdn_no) |-> fs_no == '0 && $past(fs_no) == '0);
  a_r7_fs_off_after_shdn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_no == '1 && $past(fs_no) != '1) |-> !shdn_no && !$past(shdn_no));
  a_r4_osc_idle_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_no && fs_no != '0 |-> !osc_en_o);
endmodule

// File: rtl/fan_startup_seq.sv
module fan_startup_seq
  import fan_seq_pkg::*;
#(
  parameter int unsigned SPD_W       = 3,
  parameter int unsigned START_TICKS = 8,
  localparam int unsigned HALF_TICKS = (START_TICKS / 2 > 0) ? START_TICKS / 2 : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SPD_W-1:0] wr_data_i,
  input  logic             tick_i,
  output logic [SPD_W-1:0] fs_no,
  output logic             shdn_no,
  output logic             osc_en_o
);
  seq_state_e       state;
  logic [SPD_W-1:0] speed;
  logic             tmr_clr, half_done, osc_en;

  fan_seq_ctrl #(.SPD_W(SPD_W)) u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .half_done_i(half_done), .state_o(state), .speed_o(speed), .tmr_clr_o(tmr_clr)
  );

  fan_seq_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .run_i(osc_en), .tick_i, .done_o(half_done)
  );

  fan_seq_drive #(.SPD_W(SPD_W)) u_drive (
    .clk_i, .rst_ni, .state_i(state), .speed_i(speed),
    .fs_no, .shdn_no, .osc_en_o(osc_en)
  );

  assign osc_en_o = osc_en;

  a_r11_no_change_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !wr_en_i |=> $stable(fs_no) && $stable(shdn_no) && $stable(osc_en_o));
endmodule

// File: tb/fan_startup_seq_bench.sv
`timescale 1ns/1ps
module fan_startup_seq_bench;
  localparam int W = 3;
  localparam int T = 8;
  localparam int H = T / 2;

  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, tick = 1'b0;
  logic [W-1:0] wdat = '0;
  logic [W-1:0] fs;
  logic shdn, osc;

  int errors = 0, checks = 0;
  string tag = "R1";
  bit finished = 0;

  // reference model state
  int ph = 0, left = 0;
  logic [W-1:0] spd = '0, hold = '1;

  always #2.5 clk = ~clk;

  fan_startup_seq #(.SPD_W(W), .START_TICKS(T)) u_fan_startup_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .wr_data_i(wdat), .tick_i(tick),
    .fs_no(fs), .shdn_no(shdn), .osc_en_o(osc)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; left = 0; spd = '0; hold = '1;
    end else begin
      case (ph)
        0: if (wr && wdat != 0) begin ph = 1; left = H; end
        1, 2: if (wr && wdat == 0) begin hold = '0; ph = 4; left = H; end
              else if (tick) begin left--; if (left == 0) begin ph++; left = H; end end
        3: if (wr && wdat == 0) begin hold = ~spd; ph = 4; left = H; end
        4: if (wr && wdat != 0) begin ph = 1; left = H; end
           else if (tick) begin left--; if (left == 0) ph = 0; end
        default: ph = 0;
      endcase
      if (wr) spd = wdat;
    end
  end

  task automatic chk(string t, logic [W-1:0] efs, logic esh, logic eosc);
    checks++;
    if (fs !== efs || shdn !== esh || osc !== eosc) begin
      errors++;
      $display("FAIL %s fs=%b shdn=%b osc=%b expected fs=%b shdn=%b osc=%b",
               t, fs, shdn, osc, efs, esh, eosc);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    case (ph)
      1:       chk(tag, '0, 1'b0, 1'b1);
      2:       chk(tag, '0, 1'b1, 1'b1);
      3:       chk(tag, ~spd, 1'b1, 1'b0);
      4:       chk(tag, hold, 1'b0, 1'b1);
      default: chk(tag, '1, 1'b0, 1'b0);
    endcase
  end

  task automatic write(logic [W-1:0] v);
    @(negedge clk); wr = 1'b1; wdat = v;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1"; chk("R1", '1, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", '1, 1'b0, 1'b0);

    tag = "R9"; write(3'd0); chk("R9", '1, 1'b0, 1'b0);
    tag = "R11"; ticks(3, 1); chk("R11", '1, 1'b0, 1'b0);

    tag = "R2"; write(3'd5); chk("R2", 3'b000, 1'b0, 1'b1);
    tag = "R11"; repeat (20) @(negedge clk); chk("R11", 3'b000, 1'b0, 1'b1);
    tag = "R3"; ticks(H - 1, 3); chk("R3", 3'b000, 1'b0, 1'b1);
    ticks(1, 0); chk("R3", 3'b000, 1'b1, 1'b1);
    tag = "R4"; ticks(H, 2); chk("R4", 3'b010, 1'b1, 1'b0);

    tag = "R5"; write(3'd3); chk("R5", 3'b100, 1'b1, 1'b0);
    ticks(2, 0); chk("R5", 3'b100, 1'b1, 1'b0);

    tag = "R7"; write(3'd0); chk("R7", 3'b100, 1'b0, 1'b1);
    ticks(H - 1, 1); chk("R7", 3'b100, 1'b0, 1'b1);
    ticks(1, 0); chk("R7", 3'b111, 1'b0, 1'b0);

    tag = "R6"; write(3'd1); ticks(2, 0); write(3'd6);
    chk("R6", 3'b000, 1'b0, 1'b1);
    ticks(H - 2, 0); chk("R6", 3'b000, 1'b1, 1'b1);
    ticks(H, 0); chk("R6", 3'b001, 1'b1, 1'b0);

    tag = "R7"; write(3'd0); ticks(H, 0); chk("R7", 3'b111, 1'b0, 1'b0);

    tag = "R8"; write(3'd2); ticks(2, 0); write(3'd0);
    chk("R8", 3'b000, 1'b0, 1'b1);
    ticks(H, 0); chk("R8", 3'b111, 1'b0, 1'b0);
    write(3'd2); ticks(H + 1, 0); write(3'd0);
    chk("R8", 3'b000, 1'b0, 1'b1);
    ticks(H, 0); chk("R8", 3'b111, 1'b0, 1'b0);

    tag = "R10"; write(3'd4); ticks(T, 0); chk("R10", 3'b011, 1'b1, 1'b0);
    write(3'd0); ticks(2, 0); write(3'd7);
    chk("R10", 3'b000, 1'b0, 1'b1);
    ticks(H - 1, 0); chk("R10", 3'b000, 1'b0, 1'b1);
    ticks(1, 0); chk("R10", 3'b000, 1'b1, 1'b1);
    ticks(H, 0); chk("R10", 3'b000, 1'b1, 1'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog during %s", tag);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule